// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits next to a small processor core and gathers interrupt requests from up to twelve peripheral sources: four timers, three external pins, serial receive, serial transmit, a port-change detector, an ADC and a capture/compare unit. Each source owns a sticky flag that its peripheral sets with a one-cycle event pulse. Software clears a flag by writing zero to it, modelled here as a clear strobe per bit. An enable bit and a priority bit per source come from configuration registers held elsewhere. A mode input chooses between a compatibility mode, in which every source is served at the high level, and a two-level mode, in which each priority bit picks the high or the low level.

The block drives a request line and the vector address the core should branch to. The high level uses 0x0008, the low level uses 0x0018, and 0x0000 is presented while nothing is requested. The core is modelled as three strobes: instruction boundary, vector taken and return. When the core takes a vector, the block saves the next-instruction address for that level, marks the level as in service and drops that level's global enable. A return leaves the innermost level, sets its enable again and presents the saved address.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset all flags are clear, both global enables are 0, no level is in service, `irq_o` is 0 and `vec_o` reads 0x0000.
- R2: A flag is set by its event pulse and stays set until its clear strobe. If an event and a clear for the same flag arrive in the same cycle, the flag ends up set.
- R3: A source requests service only when its flag and its enable bit are both 1 and the governing global enable is 1.
- R4: With `prio_mode_i`=0 every requesting source is served at the high level with vector 0x0008, and the priority bits have no effect.
- R5: With `prio_mode_i`=1 a source whose priority bit is 1 yields vector 0x0008 and one whose bit is 0 yields 0x0018. When both levels are requesting, 0x0008 is presented.
- R6: A vector is accepted only in a cycle with `take_i`=1, `boundary_i`=1 and `irq_o`=1. On acceptance `next_pc_i` is saved for that level, the level becomes in service and that level's global enable is cleared. `take_i` without `boundary_i` has no effect.
- R7: A high-level request preempts a low-level handler. While a high-level handler runs, `irq_o` stays 0, and a low-level request never nests inside another low-level handler.
- R8: `ret_i` leaves the innermost level in service and sets that level's enable to 1 again. `ret_pc_o` shows the address saved for the innermost level in service, or the low-level saved address when only that level or no level is in service.
- R9: The request of a level stays asserted while any enabled flag of that level remains set.
- R10: Software set and clear strobes control each global enable. In two-level mode the low level also needs the high global enable to be 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NSRC | Event pulses from peripherals, one per source |
| clr_i | input | NSRC | Write-zero clear strobes, one per flag |
| en_i | input | NSRC | Per-source enable bits |
| prio_i | input | NSRC | Per-source priority bits (1 = high) |
| prio_mode_i | input | 1 | 0 = compatibility mode, 1 = two-level mode |
| ena_hi_set_i | input | 1 | Software set of the high global enable |
| ena_hi_clr_i | input | 1 | Software clear of the high global enable |
| ena_lo_set_i | input | 1 | Software set of the low global enable |
| ena_lo_clr_i | input | 1 | Software clear of the low global enable |
| boundary_i | input | 1 | Core is at an instruction boundary |
| take_i | input | 1 | Core branches to the presented vector |
| ret_i | input | 1 | Core executes return-from-interrupt |
| next_pc_i | input | AW | Address of the next instruction to save |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | AW | Vector address to branch to |
| ret_pc_o | output | AW | Saved address for the return |
| in_hi_o | output | 1 | High level in service |
| in_lo_o | output | 1 | Low level in service |
| ena_hi_o | output | 1 | High global enable state |
| ena_lo_o | output | 1 | Low global enable state |

## Verification
Two pairs of events can land in the same cycle. A peripheral event and the software clear of the same flag can arrive together, and a return can coincide with a flag clear. The bench drives the event and the clear of one flag together while the high handler masks the request, and then returns. The flag counts as kept only if the request rises again at 0x0008 right after the return. The return-plus-clear case is judged by whether a still-pending request reappears in the cycle after the handler exits.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned VEC_RESET = 32'h0000_0000;
    localparam int unsigned VEC_HIGH  = 32'h0000_0008;
    localparam int unsigned VEC_LOW   = 32'h0000_0018;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NSRC = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flag_o
);
    typedef struct packed {
        logic [NSRC-1:0] flag;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NSRC; i++) begin
            if (clr_i[i]) bank_d.flag[i] = 1'b0;
            if (evt_i[i]) bank_d.flag[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign flag_o = bank_q.flag;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flag_o) & ~$past(clr_i)) & ~flag_o) == '0)); // R2
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_i) & ~flag_o) == '0)); // R2
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve #(
    parameter int NSRC = 12
) (
    input  logic [NSRC-1:0] flag_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] prio_i,
    input  logic            prio_mode_i,
    input  logic            ena_hi_i,
    input  logic            ena_lo_i,
    input  logic            in_hi_i,
    input  logic            in_lo_i,
    output logic            want_hi_o,
    output logic            want_lo_o
);
    logic [NSRC-1:0] live;
    logic [NSRC-1:0] hi_mask;
    logic            pend_hi;
    logic            pend_lo;

    always_comb begin
        live    = flag_i & en_i;
        hi_mask = prio_mode_i ? prio_i : '1;
        pend_hi = |(live & hi_mask);
        pend_lo = prio_mode_i && (|(live & ~hi_mask));
        want_hi_o = pend_hi && ena_hi_i && !in_hi_i;
        want_lo_o = pend_lo && ena_hi_i && ena_lo_i && !in_hi_i && !in_lo_i;
    end
endmodule

// File: rtl/irq_ctx.sv
module irq_ctx #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ena_hi_set_i,
    input  logic          ena_hi_clr_i,
    input  logic          ena_lo_set_i,
    input  logic          ena_lo_clr_i,
    input  logic          acc_i,
    input  logic          acc_hi_i,
    input  logic          ret_i,
    input  logic [AW-1:0] next_pc_i,
    output logic          ena_hi_o,
    output logic          ena_lo_o,
    output logic          in_hi_o,
    output logic          in_lo_o,
    output logic [AW-1:0] ret_pc_o
);
    import irq_pkg::*;

    typedef struct packed {
        logic          ena_hi;
        logic          ena_lo;
        logic          in_hi;
        logic          in_lo;
        logic [AW-1:0] pc_hi;
        logic [AW-1:0] pc_lo;
    } ctx_t;

    ctx_t ctx_d, ctx_q;
    lvl_e ret_lvl;

    always_comb begin
        ret_lvl = LVL_NONE;
        if (ret_i) begin
            if (ctx_q.in_hi)      ret_lvl = LVL_HIGH;
            else if (ctx_q.in_lo) ret_lvl = LVL_LOW;
        end
    end

    always_comb begin
        ctx_d = ctx_q;
        if (ena_hi_set_i) ctx_d.ena_hi = 1'b1;
        if (ena_hi_clr_i) ctx_d.ena_hi = 1'b0;
        if (ena_lo_set_i) ctx_d.ena_lo = 1'b1;
        if (ena_lo_clr_i) ctx_d.ena_lo = 1'b0;
        if (acc_i) begin
            if (acc_hi_i) begin
                ctx_d.in_hi  = 1'b1;
                ctx_d.ena_hi = 1'b0;
                ctx_d.pc_hi  = next_pc_i;
            end else begin
                ctx_d.in_lo  = 1'b1;
                ctx_d.ena_lo = 1'b0;
                ctx_d.pc_lo  = next_pc_i;
            end
        end else begin
            case (ret_lvl)
                LVL_HIGH: begin
                    ctx_d.in_hi  = 1'b0;
                    ctx_d.ena_hi = 1'b1;
                end
                LVL_LOW: begin
                    ctx_d.in_lo  = 1'b0;
                    ctx_d.ena_lo = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign ena_hi_o = ctx_q.ena_hi;
    assign ena_lo_o = ctx_q.ena_lo;
    assign in_hi_o  = ctx_q.in_hi;
    assign in_lo_o  = ctx_q.in_lo;
    assign ret_pc_o = ctx_q.in_hi ? ctx_q.pc_hi : ctx_q.pc_lo;

    AST_TAKE_DROPS_ENA: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && acc_hi_i) |=> (!ena_hi_o && in_hi_o && ret_pc_o == $past(next_pc_i))); // R6
    AST_RET_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !acc_i && in_hi_o && !ena_hi_clr_i) |=> (ena_hi_o && !in_hi_o)); // R8
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
    parameter int NSRC = 12,
    parameter int AW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] prio_i,
    input  logic            prio_mode_i,
    input  logic            ena_hi_set_i,
    input  logic            ena_hi_clr_i,
    input  logic            ena_lo_set_i,
    input  logic            ena_lo_clr_i,
    input  logic            boundary_i,
    input  logic            take_i,
    input  logic            ret_i,
    input  logic [AW-1:0]   next_pc_i,
    output logic            irq_o,
    output logic [AW-1:0]   vec_o,
    output logic [AW-1:0]   ret_pc_o,
    output logic            in_hi_o,
    output logic            in_lo_o,
    output logic            ena_hi_o,
    output logic            ena_lo_o
);
    import irq_pkg::*;

    localparam logic [AW-1:0] V_RST = AW'(VEC_RESET);
    localparam logic [AW-1:0] V_HI  = AW'(VEC_HIGH);
    localparam logic [AW-1:0] V_LO  = AW'(VEC_LOW);

    logic [NSRC-1:0] flags;
    logic            want_hi;
    logic            want_lo;
    logic            accept;

    irq_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .clr_i  (clr_i),
        .flag_o (flags)
    );

    irq_resolve #(.NSRC(NSRC)) u_resolve (
        .flag_i      (flags),
        .en_i        (en_i),
        .prio_i      (prio_i),
        .prio_mode_i (prio_mode_i),
        .ena_hi_i    (ena_hi_o),
        .ena_lo_i    (ena_lo_o),
        .in_hi_i     (in_hi_o),
        .in_lo_i     (in_lo_o),
        .want_hi_o   (want_hi),
        .want_lo_o   (want_lo)
    );

    always_comb begin
        irq_o  = want_hi || want_lo;
        vec_o  = want_hi ? V_HI : (want_lo ? V_LO : V_RST);
        accept = take_i && boundary_i && irq_o;
    end

    irq_ctx #(.AW(AW)) u_ctx (
        .clk          (clk),
        .rst_n        (rst_n),
        .ena_hi_set_i (ena_hi_set_i),
        .ena_hi_clr_i (ena_hi_clr_i),
        .ena_lo_set_i (ena_lo_set_i),
        .ena_lo_clr_i (ena_lo_clr_i),
        .acc_i        (accept),
        .acc_hi_i     (want_hi),
        .ret_i        (ret_i),
        .next_pc_i    (next_pc_i),
        .ena_hi_o     (ena_hi_o),
        .ena_lo_o     (ena_lo_o),
        .in_hi_o      (in_hi_o),
        .in_lo_o      (in_lo_o),
        .ret_pc_o     (ret_pc_o)
    );

    AST_COMPAT_HI_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (!prio_mode_i && irq_o) |-> (vec_o == V_HI)); // R4
    AST_HIGH_NOT_INTERRUPTED: assert property (@(posedge clk) disable iff (!rst_n)
        in_hi_o |-> !irq_o); // R7
    AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec_o == V_RST)); // R1
endmodule

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
    localparam int NSRC = 12;
    localparam int AW   = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] evt_i = '0, clr_i = '0, en_i = '0, prio_i = '0;
    logic            prio_mode_i = 1'b0;
    logic            ena_hi_set_i = 1'b0, ena_hi_clr_i = 1'b0;
    logic            ena_lo_set_i = 1'b0, ena_lo_clr_i = 1'b0;
    logic            boundary_i = 1'b0, take_i = 1'b0, ret_i = 1'b0;
    logic [AW-1:0]   next_pc_i = '0;
    logic            irq_o, in_hi_o, in_lo_o, ena_hi_o, ena_lo_o;
    logic [AW-1:0]   vec_o, ret_pc_o;

    vec_irq_ctrl #(.NSRC(NSRC), .AW(AW)) u0 (.*);

    always #2 clk = ~clk;

    typedef struct {
        logic        irq;
        logic [15:0] vec;
        logic        hi;
        logic        lo;
        logic        eh;
        logic        el;
        int          ret;
        string       tag;
    } exp_t;

    exp_t scb[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;
    bit   reported = 1'b0;

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
        end
    endtask

    // driver: push the expectation for the state after the coming edge
    task automatic cyc(input logic irq, input logic [15:0] vec, input logic hi,
                       input logic lo, input logic eh, input logic el,
                       input int ret, input string tag);
        exp_t e;
        e.irq = irq; e.vec = vec; e.hi = hi; e.lo = lo;
        e.eh = eh; e.el = el; e.ret = ret; e.tag = tag;
        scb.push_back(e);
        @(negedge clk);
        #1;
        evt_i = '0; clr_i = '0;
        ena_hi_set_i = 1'b0; ena_hi_clr_i = 1'b0;
        ena_lo_set_i = 1'b0; ena_lo_clr_i = 1'b0;
        take_i = 1'b0; boundary_i = 1'b0; ret_i = 1'b0;
    endtask

    // monitor: compare at the falling edge after each driven step
    initial begin
        forever begin
            @(negedge clk);
            if (scb.size() > 0) begin
                exp_t e;
                bit   ok;
                e  = scb.pop_front();
                ok = (irq_o === e.irq) && (vec_o === e.vec) && (in_hi_o === e.hi) &&
                     (in_lo_o === e.lo) && (ena_hi_o === e.eh) && (ena_lo_o === e.el) &&
                     (e.ret < 0 || ret_pc_o === 16'(e.ret));
                total++;
                if (!ok) begin
                    bad++;
                    $display("FAIL %s actual irq=%0b vec=%h hi=%0b lo=%0b eh=%0b el=%0b ret=%h expected irq=%0b vec=%h hi=%0b lo=%0b eh=%0b el=%0b ret=%0d",
                             e.tag, irq_o, vec_o, in_hi_o, in_lo_o, ena_hi_o, ena_lo_o, ret_pc_o,
                             e.irq, e.vec, e.hi, e.lo, e.eh, e.el, e.ret);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        cyc(0, 16'h0000, 0, 0, 0, 0, 0, "R1 reset state");
        // compatibility mode
        evt_i[0] = 1'b1;
        cyc(0, 16'h0000, 0, 0, 0, 0, -1, "R3 flag without enable");
        en_i[0] = 1'b1;
        cyc(0, 16'h0000, 0, 0, 0, 0, -1, "R3 no global enable");
        ena_hi_set_i = 1'b1;
        cyc(1, 16'h0008, 0, 0, 1, 0, -1, "R4 compat request high");
        prio_i = '0;
        cyc(1, 16'h0008, 0, 0, 1, 0, -1, "R4 priority bits ignored");
        take_i = 1'b1; next_pc_i = 16'h1234;
        cyc(1, 16'h0008, 0, 0, 1, 0, -1, "R6 take without boundary");
        take_i = 1'b1; boundary_i = 1'b1;
        cyc(0, 16'h0000, 1, 0, 0, 0, 16'h1234, "R6 vector accepted");
        evt_i[0] = 1'b1; clr_i[0] = 1'b1;
        cyc(0, 16'h0000, 1, 0, 0, 0, 16'h1234, "R2 event and clear together");
        ret_i = 1'b1;
        cyc(1, 16'h0008, 0, 0, 1, 0, -1, "R2 R8 flag kept, enable restored");
        clr_i[0] = 1'b1;
        cyc(0, 16'h0000, 0, 0, 1, 0, -1, "R2 clear drops request");
        // two-level mode
        prio_mode_i = 1'b1;
        prio_i = '0; prio_i[3] = 1'b1;
        en_i[3] = 1'b1; en_i[7] = 1'b1; en_i[8] = 1'b1;
        ena_lo_set_i = 1'b1;
        cyc(0, 16'h0000, 0, 0, 1, 1, -1, "R10 low enable set");
        evt_i[7] = 1'b1;
        cyc(1, 16'h0018, 0, 0, 1, 1, -1, "R5 low vector");
        evt_i[8] = 1'b1;
        cyc(1, 16'h0018, 0, 0, 1, 1, -1, "R5 two low sources");
        ena_hi_clr_i = 1'b1;
        cyc(0, 16'h0000, 0, 0, 0, 1, -1, "R10 low needs high enable");
        ena_hi_set_i = 1'b1;
        cyc(1, 16'h0018, 0, 0, 1, 1, -1, "R10 high enable back");
        take_i = 1'b1; boundary_i = 1'b1; next_pc_i = 16'h0200;
        cyc(0, 16'h0000, 0, 1, 1, 0, 16'h0200, "R6 low accepted");
        evt_i[3] = 1'b1;
        cyc(1, 16'h0008, 0, 1, 1, 0, 16'h0200, "R7 high preempts low");
        take_i = 1'b1; boundary_i = 1'b1; next_pc_i = 16'h0300;
        cyc(0, 16'h0000, 1, 1, 0, 0, 16'h0300, "R7 nested high accepted");
        ret_i = 1'b1; clr_i[3] = 1'b1;
        cyc(0, 16'h0000, 0, 1, 1, 0, 16'h0200, "R8 return to low handler");
        ret_i = 1'b1;
        cyc(1, 16'h0018, 0, 0, 1, 1, 16'h0200, "R8 leave low handler");
        clr_i[7] = 1'b1;
        cyc(1, 16'h0018, 0, 0, 1, 1, -1, "R9 one low flag left");
        clr_i[8] = 1'b1;
        cyc(0, 16'h0000, 0, 0, 1, 1, -1, "R9 all low flags clear");
        evt_i[3] = 1'b1;
        cyc(1, 16'h0008, 0, 0, 1, 1, -1, "R5 high vector");
        evt_i[7] = 1'b1; take_i = 1'b1; boundary_i = 1'b1; next_pc_i = 16'h0400;
        cyc(0, 16'h0000, 1, 0, 0, 1, 16'h0400, "R7 low blocked in high handler");
        ena_hi_set_i = 1'b1;
        cyc(0, 16'h0000, 1, 0, 1, 1, 16'h0400, "R7 no nesting with enable set");
        ret_i = 1'b1;
        cyc(1, 16'h0008, 0, 0, 1, 1, -1, "R5 high shown over low");
        clr_i[3] = 1'b1;
        cyc(1, 16'h0018, 0, 0, 1, 1, -1, "R9 low remains after high clear");
        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule